// File: doc/BRIEF.md
# Half-Word Multiply-Add Unit

This block is a 32-bit integer datapath stage. It forms the product of one 16-bit half of operand A and one 16-bit half of operand B, then adds a term taken from operand C or from operand B. Each operand half is chosen by its own select bit and widened to 32 bits under its own signedness control. Before the addition, the product can be moved up by one half-word. After the addition, the upper half of the result can be overwritten with the low half of B.

A request is presented with a one-cycle valid strobe. The result and an illegal-request flag come back one clock later, together with an output valid. Some combinations are rejected: a reserved addend mode, a request for extended-precision carry, or a request to write condition codes. A rejected request still returns a valid strobe, with the illegal flag set and the result forced to zero.

Top module: `halfmac_unit`

## Requirements
- R1: Operand A contributes bits 15:0 when `a_hi_sel`=0 and bits 31:16 when `a_hi_sel`=1. The chosen half is sign-extended when `a_signed`=1 and zero-extended when `a_signed`=0.
- R2: Operand B follows the same selection rule with `b_hi_sel` and `b_signed`. When `b_from_imm`=1, bits 15:0 of B are used whatever `b_hi_sel` holds.
- R3: The product is the low 32 bits of the two extended halves multiplied together. When `prod_shift`=1, that product is shifted left by 16 bits before the addition.
- R4: With `c_mode`=0 the addend is all 32 bits of C.
- R5: With `c_mode`=1 the addend is C bits 15:0, zero-extended. With `c_mode`=2 it is C bits 31:16, zero-extended.
- R6: With `c_mode`=4 the addend is (B << 16) + B, computed modulo 2^32. C is not used in this mode.
- R7: `c_mode` values 3, 5, 6 and 7 set `out_illegal` and force `out_result` to zero.
- R8: A request with `ext_prec`=1 or `cc_write`=1 sets `out_illegal` and forces `out_result` to zero.
- R9: When `merge_hi`=1 on a legal request, result bits 31:16 equal B bits 15:0, and result bits 15:0 keep the low half of the sum.
- R10: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, illegal requests included. It is low otherwise.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_result` on the next clock edge.
- R12: The addition wraps modulo 2^32, and no carry is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B (register value or zero-padded immediate) |
| op_c | input | 32 | Operand C |
| a_hi_sel | input | 1 | 1 selects the upper half of A |
| b_hi_sel | input | 1 | 1 selects the upper half of B |
| a_signed | input | 1 | Sign-extend the A half |
| b_signed | input | 1 | Sign-extend the B half |
| b_from_imm | input | 1 | B is an immediate; the lower half is forced |
| prod_shift | input | 1 | Shift the product left by 16 |
| merge_hi | input | 1 | Replace result bits 31:16 with B bits 15:0 |
| c_mode | input | 3 | Addend selection mode |
| ext_prec | input | 1 | Extended-precision request (rejected) |
| cc_write | input | 1 | Condition-code write request (rejected) |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Registered result |
| out_illegal | output | 1 | Registered illegal-request flag |

## Verification
Every result and illegal flag is due on the first rising edge after the request's cycle, because a single register stage sits between the inputs and the outputs. The driver changes inputs on falling edges and pushes one expected item per request. A monitor wakes 2 ns after each rising edge and pops exactly one item whenever a request was captured on that edge. When no request was captured, the monitor requires `out_valid` to be low. A reset is checked on the edge where it is sampled, including the case where a request arrives in the same cycle.

// File: rtl/halfmac_pkg.sv
package halfmac_pkg;
  localparam int unsigned CSEL_W = 3;

  typedef enum logic [CSEL_W-1:0] {
    CSEL_FULL = 3'd0,
    CSEL_LO   = 3'd1,
    CSEL_HI   = 3'd2,
    CSEL_RSVD = 3'd3,
    CSEL_BDUP = 3'd4
  } csel_e;
endpackage

// File: rtl/halfmac_half_ext.sv
module halfmac_half_ext #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic              hi_sel,
  input  logic              force_lo,
  input  logic              sgn,
  output logic [DATA_W-1:0] ext
);
  localparam int unsigned HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] widen(logic [HALF_W-1:0] h, logic s);
    return s ? {{HALF_W{h[HALF_W-1]}}, h} : {{HALF_W{1'b0}}, h};
  endfunction

  logic              take_hi;
  logic [HALF_W-1:0] half_v;

  assign take_hi = hi_sel & ~force_lo;
  assign half_v  = take_hi ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
  assign ext     = widen(half_v, sgn);
endmodule

// File: rtl/halfmac_addend_sel.sv
module halfmac_addend_sel
  import halfmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [CSEL_W-1:0] c_mode,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  output logic [DATA_W-1:0] addend,
  output logic              mode_bad
);
  localparam int unsigned HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] dup_b(logic [DATA_W-1:0] b);
    return (b << HALF_W) + b;
  endfunction

  always_comb begin
    addend   = '0;
    mode_bad = 1'b0;
    unique case (csel_e'(c_mode))
      CSEL_FULL: addend = op_c;
      CSEL_LO:   addend = {{HALF_W{1'b0}}, op_c[HALF_W-1:0]};
      CSEL_HI:   addend = {{HALF_W{1'b0}}, op_c[DATA_W-1:HALF_W]};
      CSEL_BDUP: addend = dup_b(op_b);
      default:   mode_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/halfmac_unit.sv
module halfmac_unit
  import halfmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  input  logic              a_hi_sel,
  input  logic              b_hi_sel,
  input  logic              a_signed,
  input  logic              b_signed,
  input  logic              b_from_imm,
  input  logic              prod_shift,
  input  logic              merge_hi,
  input  logic [CSEL_W-1:0] c_mode,
  input  logic              ext_prec,
  input  logic              cc_write,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NOPS   = 2;

  function automatic logic [DATA_W-1:0] mul_wrap(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    return x * y;
  endfunction

  function automatic logic [DATA_W-1:0] merge_upper(logic [DATA_W-1:0] s, logic [DATA_W-1:0] b);
    return {b[HALF_W-1:0], s[HALF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] src_w  [NOPS];
  logic              hi_w   [NOPS];
  logic              sg_w   [NOPS];
  logic              flo_w  [NOPS];
  logic [DATA_W-1:0] ext_w  [NOPS];

  assign src_w[0] = op_a;  assign hi_w[0] = a_hi_sel; assign sg_w[0] = a_signed; assign flo_w[0] = 1'b0;
  assign src_w[1] = op_b;  assign hi_w[1] = b_hi_sel; assign sg_w[1] = b_signed; assign flo_w[1] = b_from_imm;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_ext
    halfmac_half_ext #(.DATA_W(DATA_W)) ext_i (
      .word     (src_w[gi]),
      .hi_sel   (hi_w[gi]),
      .force_lo (flo_w[gi]),
      .sgn      (sg_w[gi]),
      .ext      (ext_w[gi])
    );
  end

  logic [DATA_W-1:0] addend;
  logic              mode_bad;

  halfmac_addend_sel #(.DATA_W(DATA_W)) addend_i (
    .c_mode   (c_mode),
    .op_b     (op_b),
    .op_c     (op_c),
    .addend   (addend),
    .mode_bad (mode_bad)
  );

  logic [DATA_W-1:0] prod_raw;
  logic [DATA_W-1:0] prod_adj;
  logic [DATA_W-1:0] sum_raw;
  logic [DATA_W-1:0] res_next;
  logic              req_illegal;

  assign prod_raw    = mul_wrap(ext_w[0], ext_w[1]);
  assign prod_adj    = prod_shift ? (prod_raw << HALF_W) : prod_raw;
  assign sum_raw     = prod_adj + addend;
  assign res_next    = merge_hi ? merge_upper(sum_raw, op_b) : sum_raw;
  assign req_illegal = mode_bad | ext_prec | cc_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & req_illegal;
      if (in_valid) out_result <= req_illegal ? '0 : res_next;
    end
  end
endmodule

// File: rtl/halfmac_unit_chk.sv
module halfmac_unit_chk
  import halfmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [DATA_W/2-1:0] b_lo,
  input logic [CSEL_W-1:0]   c_mode,
  input logic                merge_hi,
  input logic                ext_prec,
  input logic                cc_write,
  input logic                req_illegal,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_result,
  input logic                out_illegal
);
  localparam int unsigned HALF_W = DATA_W / 2;

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && out_result == '0));

  // R7
  mode_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (c_mode == CSEL_RSVD || c_mode > CSEL_BDUP)) |=> out_illegal);

  // R8
  ctl_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (ext_prec || cc_write)) |=> out_illegal);

  // R8
  illegal_track_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_illegal == $past(req_illegal)));

  // R9
  merge_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && merge_hi && !req_illegal) |=> (out_result[DATA_W-1:HALF_W] == $past(b_lo)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_illegal && out_result == '0));
endmodule

bind halfmac_unit halfmac_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .b_lo        (op_b[DATA_W/2-1:0]),
  .c_mode      (c_mode),
  .merge_hi    (merge_hi),
  .ext_prec    (ext_prec),
  .cc_write    (cc_write),
  .req_illegal (req_illegal),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/halfmac_unit_tb_top.sv
module halfmac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0;
  logic        a_hi_sel = 1'b0, b_hi_sel = 1'b0, a_signed = 1'b0, b_signed = 1'b0;
  logic        b_from_imm = 1'b0, prod_shift = 1'b0, merge_hi = 1'b0;
  logic [2:0]  c_mode = '0;
  logic        ext_prec = 1'b0, cc_write = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  halfmac_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .a_hi_sel(a_hi_sel), .b_hi_sel(b_hi_sel), .a_signed(a_signed), .b_signed(b_signed),
    .b_from_imm(b_from_imm), .prod_shift(prod_shift), .merge_hi(merge_hi),
    .c_mode(c_mode), .ext_prec(ext_prec), .cc_write(cc_write),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  typedef struct {
    logic [31:0] res;
    logic        ill;
    string       tag;
  } item_t;

  item_t sb_q[$];

  function automatic item_t model(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                  logic ahi, logic bhi, logic as, logic bs, logic imm,
                                  logic ps, logic mg, logic [2:0] m, logic ep, logic cw,
                                  string tag);
    item_t it;
    logic [15:0] ha, hb;
    longint pa, pb, prod, add, s;
    longint mask = 64'hFFFF_FFFF;
    ha = ahi ? a[31:16] : a[15:0];
    hb = (bhi && !imm) ? b[31:16] : b[15:0];
    pa = as ? longint'($signed(ha)) : longint'(ha);
    pb = bs ? longint'($signed(hb)) : longint'(hb);
    prod = (pa * pb) & mask;
    if (ps) prod = (prod * 65536) & mask;
    add = 0;
    it.ill = ep || cw;
    case (m)
      3'd0: add = longint'(c);
      3'd1: add = longint'(c) & 64'hFFFF;
      3'd2: add = longint'(c) / 65536;
      3'd4: add = (longint'(b) * 65536 + longint'(b)) & mask;
      default: it.ill = 1'b1;
    endcase
    s = (prod + add) & mask;
    if (mg) s = (s & 64'hFFFF) + (longint'(b) & 64'hFFFF) * 65536;
    it.res = it.ill ? 32'd0 : s[31:0];
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                       logic ahi, logic bhi, logic as, logic bs, logic imm,
                       logic ps, logic mg, logic [2:0] m, logic ep, logic cw, string tag);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; op_c = c;
    a_hi_sel = ahi; b_hi_sel = bhi; a_signed = as; b_signed = bs; b_from_imm = imm;
    prod_shift = ps; merge_hi = mg; c_mode = m; ext_prec = ep; cc_write = cw;
    sb_q.push_back(model(a, b, c, ahi, bhi, as, bs, imm, ps, mg, m, ep, cw, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: results are due on the edge after the request.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst) begin
        sb_q.delete();
      end else if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(out_valid == 1'b1, {it.tag, " R10 valid"}, 32'(out_valid), 32'd1);
        check(out_illegal == it.ill, {it.tag, " illegal flag"}, 32'(out_illegal), 32'(it.ill));
        check(out_result == it.res, {it.tag, " result"}, out_result, it.res);
      end else begin
        check(out_valid == 1'b0, "R10 idle valid", 32'(out_valid), 32'd0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    // R11: cleared state after reset
    check(out_valid == 1'b0 && out_illegal == 1'b0, "R11 reset flags", {30'd0, out_valid, out_illegal}, 32'd0);
    check(out_result == 32'd0, "R11 reset result", out_result, 32'd0);

    // R1: A half selection and extension
    drive(32'h8003_0005, 32'h0000_0007, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R1 lo unsigned");
    drive(32'hFFFE_0005, 32'h0000_0003, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R1 hi signed");
    drive(32'hFFFE_0005, 32'h0000_0003, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R1 hi unsigned");
    // R2: B half selection, immediate forces low half
    drive(32'h0000_0002, 32'h8000_0009, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R2 hi signed");
    drive(32'h0000_0002, 32'h8000_0009, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R2 imm forces lo");
    // R3: product shift
    drive(32'h0000_1234, 32'h0000_0010, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R3 shifted");
    drive(32'h0000_FFFF, 32'h0000_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R3 signed neg neg");
    // R4, R5, R6: addend modes
    drive(32'h0000_0003, 32'h0000_0004, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R4 full C");
    drive(32'h0000_0003, 32'h0000_0004, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, "R5 low C");
    drive(32'h0000_0003, 32'h0000_0004, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, "R5 high C");
    drive(32'h0000_0003, 32'h0001_0004, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, "R6 B dup");
    // R7: reserved modes
    for (int m = 3; m < 8; m++) begin
      if (m == 4) continue;
      drive(32'h0000_0003, 32'h0000_0004, 32'h1111_1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'(m), 1'b0, 1'b0, "R7 reserved mode");
    end
    idle(1);
    // R8: rejected control flags
    drive(32'h0000_0003, 32'h0000_0004, 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, "R8 ext precision");
    drive(32'h0000_0003, 32'h0000_0004, 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, "R8 cc write");
    // R9: merge
    drive(32'h0000_0100, 32'hABCD_1357, 32'h0000_0022, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, "R9 merge");
    drive(32'h0000_0100, 32'h0000_2468, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, "R9 merge shift dup");
    // R12: wrap
    drive(32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R12 wrap");
    drive(32'h0000_FFFF, 32'h0000_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, "R12 wrap shift");
    idle(2);

    // R11: reset with a request in the same cycle
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; c_mode = 3'd3;
    @(posedge clk); #2;
    check(out_valid == 1'b0 && out_illegal == 1'b0, "R11 reset over request", {30'd0, out_valid, out_illegal}, 32'd0);
    check(out_result == 32'd0, "R11 reset result", out_result, 32'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    idle(1);

    // R10: mixed back-to-back and gapped traffic
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'd0) idle(1);
      drive(lfsr * 32'h9E37_79B9, lfsr ^ 32'h5A5A_A5A5, {lfsr[15:0], lfsr[31:16]},
            lfsr[4], lfsr[5], lfsr[6], lfsr[7], lfsr[8], lfsr[9], lfsr[10],
            3'(lfsr[13:11] % 5), 1'b0, 1'b0, "R10 stream");
    end
    idle(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule